// File: doc/BRIEF.md
# Register Rename History Buffer

This block keeps an age-ordered log of destination-register renames for a single-threaded out-of-order core. Each log entry pairs an instruction sequence number with an architectural register, the physical register just allocated to it, and the physical register that held it before. Rename logic pushes up to `RW` entries per cycle. Commit and squash requests each carry a sequence number. The block answers them by writing to a map table and a free list that sit outside it.

A commit number is latched and stays in force. From the oldest end, up to `CW` entries per cycle whose sequence number is at or below it are retired, and each retired entry's previous physical register is released. A squash number starts an undo walk from the youngest end, one entry per cycle. Each entry younger than the squash point restores its architectural register to the previous physical register and releases its new one. `busy_o` stays high for the whole walk.

The buffer never drops an entry. Input readiness falls whenever a full group of `RW` entries might not fit, and it also falls during a walk. Sequence numbers are compared as fixed-width unsigned values and do not wrap.

Top module: `rhb_top`

## Requirements
- R1: After reset the buffer is empty: `ins_ready_o`=1, `busy_o`=0, `restore_valid_o`=0 and `free_valid_o`=0.
- R2: When `ins_ready_o` is 1 at a clock edge, every lane with `ins_valid_i` set is stored, youngest at the end, in ascending lane order; invalid lanes leave no gap. When `ins_ready_o` is 0, the inserted lanes are ignored.
- R3: `ins_ready_o` is 1 exactly when no undo walk is active and at least `RW` slots are free.
- R4: `busy_o` rises in the cycle after a squash request and stays high while the youngest entry's sequence number is greater than the latched squash number. While it is greater, `restore_valid_o` is 1, `restore_arch_o`/`restore_phys_o` give that entry's architectural and previous physical register, and the entry is removed at the next edge.
- R5: Each undo step also releases the undone entry's new physical register on free lane 0.
- R6: With a commit number latched, the oldest entries with sequence number less than or equal to it are released, up to `CW` per cycle, in age order. Each is released on lanes filled contiguously from lane 0, and each lane carries that entry's previous physical register.
- R7: No commit release happens while `busy_o` is 1. A commit number received during a walk is kept and acts after the walk.
- R8: A latched commit number stays in force, so entries inserted later with a sequence number at or below it are also released.
- R9: A squash whose number is not below the youngest entry's number, or a squash on an empty buffer, holds `busy_o` for exactly one cycle and restores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | RW | Per-lane insert valid |
| ins_seq_i | input | RW*SEQ_W | Per-lane sequence number |
| ins_arch_i | input | RW*ARCH_W | Per-lane architectural register |
| ins_new_i | input | RW*PHYS_W | Per-lane newly allocated physical register |
| ins_old_i | input | RW*PHYS_W | Per-lane previous physical register |
| ins_ready_o | output | 1 | Room for a full insert group |
| commit_valid_i | input | 1 | Latch a commit number |
| commit_seq_i | input | SEQ_W | Commit sequence number |
| squash_valid_i | input | 1 | Start an undo walk |
| squash_seq_i | input | SEQ_W | Squash sequence number; younger entries are undone |
| busy_o | output | 1 | Undo walk in progress |
| restore_valid_o | output | 1 | Map restore write valid |
| restore_arch_o | output | ARCH_W | Architectural register to restore |
| restore_phys_o | output | PHYS_W | Physical register written back to the map |
| free_valid_o | output | CW | Per-lane free-list release valid |
| free_phys_o | output | CW*PHYS_W | Per-lane released physical register |

## Verification
The first stimulus fills the buffer with back-to-back two-lane groups until readiness falls, then keeps pushing. This separates correct stalling from silent overwrite and drop. Further stimulus squashes at the youngest entry, squashes deep into the buffer, and issues a commit in the same cycle as a squash. These cases distinguish a one-cycle empty walk from a full youngest-first walk, and a commit paused by the walk from one that races it. Random mixes of sparse lane masks, partial commits and squashes, checked every cycle against a queue model, show whether lane compaction, age order and multi-lane release stay consistent across wrap of the circular storage.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  parameter int SEQ_W  = 16;
  parameter int ARCH_W = 5;
  parameter int PHYS_W = 7;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [ARCH_W-1:0] arch;
    logic [PHYS_W-1:0] new_p;
    logic [PHYS_W-1:0] old_p;
  } hist_t;
endpackage

// File: rtl/rhb_lane_pack.sv
module rhb_lane_pack #(
  parameter int RW   = 2,
  parameter int RW_W = $clog2(RW + 1)
) (
  input  logic [RW-1:0]   valid_i,
  output logic [RW_W-1:0] offs_o [RW],
  output logic [RW_W-1:0] total_o
);
  // prefix count gives each valid lane its slot behind the tail
  always_comb begin
    logic [RW_W-1:0] acc;
    acc = '0;
    for (int l = 0; l < RW; l++) begin
      offs_o[l] = acc;
      acc = acc + RW_W'(valid_i[l]);
    end
    total_o = acc;
  end
endmodule

// File: rtl/rhb_retire_scan.sv
module rhb_retire_scan #(
  parameter int CW    = 2,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 5,
  parameter int CW_W  = $clog2(CW + 1)
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] avail_i,
  input  logic [SEQ_W-1:0] lim_i,
  input  logic [SEQ_W-1:0] seq_i [CW],
  output logic [CW-1:0]    take_o,
  output logic [CW_W-1:0]  n_o
);
  // stop at the first entry that is absent or too young
  always_comb begin
    logic run;
    run = en_i;
    n_o = '0;
    for (int i = 0; i < CW; i++) begin
      take_o[i] = run && (avail_i > CNT_W'(i)) && (seq_i[i] <= lim_i);
      run = take_o[i];
      n_o = n_o + CW_W'(take_o[i]);
    end
  end
endmodule

// File: rtl/rhb_top.sv
module rhb_top
  import rhb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RW    = 2,
  parameter int CW    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [RW-1:0]        ins_valid_i,
  input  logic [RW*SEQ_W-1:0]  ins_seq_i,
  input  logic [RW*ARCH_W-1:0] ins_arch_i,
  input  logic [RW*PHYS_W-1:0] ins_new_i,
  input  logic [RW*PHYS_W-1:0] ins_old_i,
  output logic                 ins_ready_o,
  input  logic                 commit_valid_i,
  input  logic [SEQ_W-1:0]     commit_seq_i,
  input  logic                 squash_valid_i,
  input  logic [SEQ_W-1:0]     squash_seq_i,
  output logic                 busy_o,
  output logic                 restore_valid_o,
  output logic [ARCH_W-1:0]    restore_arch_o,
  output logic [PHYS_W-1:0]    restore_phys_o,
  output logic [CW-1:0]        free_valid_o,
  output logic [CW*PHYS_W-1:0] free_phys_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int RW_W  = $clog2(RW + 1);
  localparam int CW_W  = $clog2(CW + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH - RW);

  hist_t            mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sq_q, cm_q;
  logic [SEQ_W-1:0] sq_seq_q, cm_seq_q;

  hist_t            in_e [RW];
  logic [RW_W-1:0]  offs [RW];
  logic [RW_W-1:0]  n_ins;
  logic [SEQ_W-1:0] win_seq [CW];
  logic [PHYS_W-1:0] win_old [CW];
  logic [CW-1:0]    take;
  logic [CW_W-1:0]  n_take;
  hist_t            yng;
  logic             fire;

  for (genvar l = 0; l < RW; l++) begin : g_lane
    assign in_e[l].seq   = ins_seq_i[l*SEQ_W +: SEQ_W];
    assign in_e[l].arch  = ins_arch_i[l*ARCH_W +: ARCH_W];
    assign in_e[l].new_p = ins_new_i[l*PHYS_W +: PHYS_W];
    assign in_e[l].old_p = ins_old_i[l*PHYS_W +: PHYS_W];
  end

  rhb_lane_pack #(.RW(RW), .RW_W(RW_W)) u_pack (
    .valid_i (ins_valid_i),
    .offs_o  (offs),
    .total_o (n_ins)
  );

  for (genvar i = 0; i < CW; i++) begin : g_win
    assign win_seq[i] = mem[PTR_W'(head_q + PTR_W'(i))].seq;
    assign win_old[i] = mem[PTR_W'(head_q + PTR_W'(i))].old_p;
  end

  rhb_retire_scan #(.CW(CW), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .CW_W(CW_W)) u_scan (
    .en_i    (cm_q && !sq_q),
    .avail_i (cnt_q),
    .lim_i   (cm_seq_q),
    .seq_i   (win_seq),
    .take_o  (take),
    .n_o     (n_take)
  );

  assign yng             = mem[PTR_W'(tail_q - 1'b1)];
  assign ins_ready_o     = !sq_q && (cnt_q <= LIMIT);
  assign fire            = ins_ready_o;
  assign busy_o          = sq_q;
  assign restore_valid_o = sq_q && (cnt_q != '0) && (yng.seq > sq_seq_q);
  assign restore_arch_o  = yng.arch;
  assign restore_phys_o  = yng.old_p;

  for (genvar i = 0; i < CW; i++) begin : g_free
    if (i == 0) begin : g_l0
      assign free_valid_o[i] = restore_valid_o || take[i];
      assign free_phys_o[i*PHYS_W +: PHYS_W] = restore_valid_o ? yng.new_p : win_old[i];
    end else begin : g_ln
      assign free_valid_o[i] = !restore_valid_o && take[i];
      assign free_phys_o[i*PHYS_W +: PHYS_W] = win_old[i];
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < RW; l++)
      if (fire && ins_valid_i[l]) mem[PTR_W'(tail_q + PTR_W'(offs[l]))] <= in_e[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q   <= '0;
      tail_q   <= '0;
      cnt_q    <= '0;
      sq_q     <= 1'b0;
      sq_seq_q <= '0;
      cm_q     <= 1'b0;
      cm_seq_q <= '0;
    end else begin
      tail_q <= tail_q + (fire ? PTR_W'(n_ins) : '0) - PTR_W'(restore_valid_o);
      head_q <= head_q + PTR_W'(n_take);
      cnt_q  <= cnt_q + (fire ? CNT_W'(n_ins) : '0) - CNT_W'(n_take)
                - CNT_W'(restore_valid_o);
      if (squash_valid_i) begin
        sq_q     <= 1'b1;
        sq_seq_q <= squash_seq_i;
      end else if (!restore_valid_o) begin
        sq_q <= 1'b0;
      end
      if (commit_valid_i) begin
        cm_q     <= 1'b1;
        cm_seq_q <= commit_seq_i;
      end
    end
  end
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
  parameter int CW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ins_ready_o,
  input logic          squash_valid_i,
  input logic          busy_o,
  input logic          restore_valid_o,
  input logic [CW-1:0] free_valid_o
);
  AST_RESTORE_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_valid_o |-> busy_o); // R4
  AST_BUSY_AFTER_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i |=> busy_o); // R4
  AST_UNDO_FREES_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_valid_o |-> free_valid_o[0]); // R5
  AST_FREE_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_valid_o & (free_valid_o + 1'b1)) == '0); // R6
  AST_NO_COMMIT_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones(free_valid_o) == (restore_valid_o ? 1 : 0))); // R7
  AST_STALL_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ins_ready_o); // R3
endmodule

bind rhb_top rhb_checker #(.CW(CW)) u_rhb_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ins_ready_o     (ins_ready_o),
  .squash_valid_i  (squash_valid_i),
  .busy_o          (busy_o),
  .restore_valid_o (restore_valid_o),
  .free_valid_o    (free_valid_o)
);

// File: tb/tb_rhb_top.sv
module tb_rhb_top;
  import rhb_pkg::*;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int RW    = 2;
  localparam int CW    = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [RW-1:0]        ins_valid = '0;
  logic [RW*SEQ_W-1:0]  ins_seq = '0;
  logic [RW*ARCH_W-1:0] ins_arch = '0;
  logic [RW*PHYS_W-1:0] ins_new = '0, ins_old = '0;
  logic                 ins_ready;
  logic                 cm_v = 1'b0, sq_v = 1'b0;
  logic [SEQ_W-1:0]     cm_s = '0, sq_s = '0;
  logic                 busy, rv;
  logic [ARCH_W-1:0]    r_arch;
  logic [PHYS_W-1:0]    r_phys;
  logic [CW-1:0]        fv;
  logic [CW*PHYS_W-1:0] fp;

  always #(CLK_P/2) clk = ~clk;

  rhb_top #(.DEPTH(DEPTH), .RW(RW), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_valid_i(ins_valid), .ins_seq_i(ins_seq), .ins_arch_i(ins_arch),
    .ins_new_i(ins_new), .ins_old_i(ins_old), .ins_ready_o(ins_ready),
    .commit_valid_i(cm_v), .commit_seq_i(cm_s),
    .squash_valid_i(sq_v), .squash_seq_i(sq_s),
    .busy_o(busy), .restore_valid_o(rv), .restore_arch_o(r_arch),
    .restore_phys_o(r_phys), .free_valid_o(fv), .free_phys_o(fp)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  hist_t q[$];
  bit m_sq = 0, m_cm = 0;
  logic [SEQ_W-1:0] m_sq_seq = '0, m_cm_seq = '0;
  int next_seq = 1;
  int last_cm = 0;

  // stimulus for the next edge
  logic [RW-1:0] d_valid;
  hist_t d_e [RW];
  bit d_cm, d_sq;
  logic [SEQ_W-1:0] d_cm_s, d_sq_s;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ready();
    return !m_sq && (DEPTH - q.size() >= RW);
  endfunction

  function automatic bit exp_rv();
    return m_sq && q.size() > 0 && q[$].seq > m_sq_seq;
  endfunction

  function automatic int exp_take();
    int n = 0;
    if (!m_cm || m_sq) return 0;
    while (n < CW && n < q.size() && q[n].seq <= m_cm_seq) n++;
    return n;
  endfunction

  task automatic compare();
    bit r;
    int nt;
    r  = exp_rv();
    nt = exp_take();
    chk(ins_ready == exp_ready(), "R3", "ins_ready", int'(ins_ready), int'(exp_ready()));
    chk(busy == m_sq, "R4", "busy", int'(busy), int'(m_sq));
    chk(rv == r, "R4", "restore_valid", int'(rv), int'(r));
    if (r) begin
      chk(r_arch == q[$].arch, "R4", "restore_arch", int'(r_arch), int'(q[$].arch));
      chk(r_phys == q[$].old_p, "R4", "restore_phys", int'(r_phys), int'(q[$].old_p));
      chk(fv == CW'(1), "R5", "free_valid in walk", int'(fv), 1);
      chk(fp[PHYS_W-1:0] == q[$].new_p, "R5", "free_phys undo", int'(fp[PHYS_W-1:0]),
          int'(q[$].new_p));
    end else begin
      for (int i = 0; i < CW; i++) begin
        chk(fv[i] == (i < nt), m_sq ? "R7" : "R6", "free_valid lane", int'(fv[i]),
            int'(i < nt));
        if (i < nt)
          chk(fp[i*PHYS_W +: PHYS_W] == q[i].old_p, "R6", "free_phys commit",
              int'(fp[i*PHYS_W +: PHYS_W]), int'(q[i].old_p));
      end
    end
  endtask

  // apply stimulus at the negedge and advance the model to the next edge
  task automatic cycle();
    bit r, rdy;
    int nt;
    @(negedge clk);
    compare();
    r = exp_rv(); nt = exp_take(); rdy = exp_ready();
    ins_valid = d_valid;
    for (int l = 0; l < RW; l++) begin
      ins_seq[l*SEQ_W +: SEQ_W]    = d_e[l].seq;
      ins_arch[l*ARCH_W +: ARCH_W] = d_e[l].arch;
      ins_new[l*PHYS_W +: PHYS_W]  = d_e[l].new_p;
      ins_old[l*PHYS_W +: PHYS_W]  = d_e[l].old_p;
    end
    cm_v = d_cm; cm_s = d_cm_s; sq_v = d_sq; sq_s = d_sq_s;
    if (r) void'(q.pop_back());
    for (int i = 0; i < nt; i++) void'(q.pop_front());
    if (rdy)
      for (int l = 0; l < RW; l++) if (d_valid[l]) q.push_back(d_e[l]);
    if (d_sq) begin m_sq = 1; m_sq_seq = d_sq_s; end
    else if (!r) m_sq = 0;
    if (d_cm) begin m_cm = 1; m_cm_seq = d_cm_s; end
    d_valid = '0; d_cm = 0; d_sq = 0;
  endtask

  // build an insert group; sequence numbers only advance if accepted
  task automatic mk_ins(input logic [RW-1:0] mask);
    d_valid = mask;
    for (int l = 0; l < RW; l++) begin
      d_e[l].seq   = SEQ_W'(next_seq);
      d_e[l].arch  = ARCH_W'($urandom);
      d_e[l].new_p = PHYS_W'($urandom);
      d_e[l].old_p = PHYS_W'($urandom);
      if (mask[l] && exp_ready()) next_seq++;
    end
  endtask

  task automatic do_commit(input int s);
    d_cm = 1; d_cm_s = SEQ_W'(s); last_cm = s;
  endtask

  task automatic do_squash(input int s);
    d_sq = 1; d_sq_s = SEQ_W'(s); next_seq = s + 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    d_valid = '0; d_cm = 0; d_sq = 0; d_cm_s = '0; d_sq_s = '0;
    for (int l = 0; l < RW; l++) d_e[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(ins_ready == 1'b1, "R1", "ready after reset", int'(ins_ready), 1);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(rv == 1'b0, "R1", "restore after reset", int'(rv), 0);
    chk(fv == '0, "R1", "free after reset", int'(fv), 0);

    // fill until stalled, keep pushing (R2, R3)
    repeat (DEPTH/RW + 3) begin mk_ins('1); cycle(); end
    @(negedge clk);
    chk(ins_ready == 1'b0, "R3", "ready low when full", int'(ins_ready), 0);
    chk(q.size() == DEPTH, "R2", "model occupancy", q.size(), DEPTH);

    // R9: squash at youngest entry, one busy cycle, nothing undone
    do_squash(next_seq - 1); cycle();
    @(negedge clk);
    chk(busy == 1'b1 && rv == 1'b0, "R9", "empty walk", int'({busy, rv}), 2);
    cycle(); cycle();

    // R6: partial commit
    do_commit(5); repeat (4) cycle();

    // R7: commit and deep squash in the same cycle
    do_squash(9); do_commit(8);
    cycle();
    repeat (DEPTH) cycle();

    // R8: sparse inserts below a standing commit number
    mk_ins(2'b10); cycle();
    mk_ins(2'b01); cycle();
    repeat (4) cycle();
    do_commit(next_seq - 1); repeat (6) cycle();
    do_commit(next_seq + 3); mk_ins('1); cycle();
    mk_ins('1); cycle();
    repeat (6) cycle();

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int p;
      p = int'($urandom_range(0, 99));
      mk_ins(RW'($urandom));
      if (p < 4 && next_seq - 1 >= last_cm) do_squash(int'($urandom_range(last_cm, next_seq - 1)));
      else if (p < 20 && !m_sq && next_seq - 1 >= last_cm)
        do_commit(int'($urandom_range(last_cm, next_seq - 1)));
      cycle();
    end

    // drain
    do_commit(next_seq - 1);
    repeat (DEPTH + 4) cycle();
    chk(q.size() == 0, "R6", "model drained", q.size(), 0);
    @(negedge clk);
    chk(ins_ready == 1'b1 && fv == '0, "R6", "idle after drain", int'({ins_ready, fv}), 4);
    finish_run();
  end
endmodule